// File: doc/BRIEF.md
# Link Power-Up Configuration Sequencer

This block walks a serial-link endpoint from power-on reset to an operational state. Straight after reset it picks the source of the device configuration. A device that holds programmed fuses loads them. An unprogrammed device takes its settings over a two-wire register bus, or it waits on the in-band control channel carried by the high-speed link. A strap pin chooses between those two. The in-band choice cannot work without fuses, because no high-speed link exists before configuration. In that case the sequencer parks in an unreachable state and reports it.

Once configuration is complete, a power-up phase waits for every subsystem ready flag. A programmable watchdog bounds this wait. When all flags are present the endpoint is declared ready, and both control paths open. The in-band path opens only when the operating-mode pins select transceiver operation. Until then at most one configuration path is ever enabled.

Top module: `lnk_pwrup_seq`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the next state is power-on (`state_o` = 3'b000). In power-on `ready_o`, `fuse_req_o`, `twi_en_o`, `inband_en_o` and `wdog_to_o` are all low.
- R2: From power-on with `fused_i` high, the sequencer enters fuse loading (3'b001) with `fuse_req_o` high and neither path enabled. It stays there until `fuse_done_i` is high at an edge, and then moves to the power-up phase (3'b100).
- R3: From power-on with `fused_i` low and `cfg_sel_i` low, it enters the bus-wait state (3'b010) with only `twi_en_o` high. It stays there until `cfg_done_i` is high, then moves to power-up, where `twi_en_o` remains high.
- R4: From power-on with `fused_i` low and `cfg_sel_i` high, it enters the unreachable state (3'b011) and never leaves it except through reset, whatever the done strobes and ready flags do. There `twi_en_o` is low and `inband_en_o` follows the transceiver mode.
- R5: The power-up phase moves to ready (3'b101, `ready_o` high) only once all `N_RDY` bits of `sub_rdy_i` are high; a partial set keeps it waiting.
- R6: In ready, `twi_en_o` is high, and `inband_en_o` is high exactly when `mode_i` = 2'b10 (transceiver). Codes 2'b00 (receiver), 2'b01 (transmitter) and 2'b11 (reserved) keep it low.
- R7: In every state other than ready, `twi_en_o` and `inband_en_o` are never high together.
- R8: If the power-up phase lasts `wdog_lim_i`+1 cycles without all ready flags, the sequencer enters timeout (3'b110). Timeout holds until reset with `wdog_to_o` high and both paths disabled.
- R9: A high `fused_i` takes priority over `cfg_sel_i`: a fused device always loads its fuses.
- R10: Reset returns the sequencer to power-on from any state, including ready and timeout.
- R11: `fuse_req_o` is high only in the fuse-loading state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fused_i | input | 1 | Device holds programmed fuse values |
| fuse_done_i | input | 1 | Fuse load complete strobe |
| cfg_sel_i | input | 1 | Unfused path select: 0 two-wire bus, 1 in-band channel |
| cfg_done_i | input | 1 | Config-done register bit written over the bus |
| mode_i | input | 2 | Operating mode: 00 receiver, 01 transmitter, 10 transceiver, 11 reserved |
| sub_rdy_i | input | N_RDY | Subsystem ready flags, asynchronous |
| wdog_lim_i | input | WDOG_W | Power-up watchdog limit in cycles |
| fuse_req_o | output | 1 | Fuse load request |
| twi_en_o | output | 1 | Two-wire bus enable |
| inband_en_o | output | 1 | In-band control channel enable |
| state_o | output | 3 | Current state code |
| ready_o | output | 1 | Endpoint ready |
| wdog_to_o | output | 1 | Power-up watchdog expired |

## Verification
The assertions assume that `rst_i` is high for at least one edge before any checked behaviour. They also assume that `fused_i` and `cfg_sel_i` are stable straps while power-on is left, since only that one cycle samples them. The stimulus sets the straps and the mode before raising reset and changes them only under reset. The one exception is `mode_i`, which is toggled in the ready state on purpose. Ready flags are driven at negative edges and pass through the synchronizer, so the bench waits several cycles before it judges any transition that depends on them.

// File: rtl/lnk_pwrup_pkg.sv
`timescale 1ns/1ps
package lnk_pwrup_pkg;

    typedef enum logic [2:0] {
        ST_POR     = 3'b000,
        ST_FUSE    = 3'b001,
        ST_BUSWAIT = 3'b010,
        ST_NOLINK  = 3'b011,
        ST_PWRUP   = 3'b100,
        ST_READY   = 3'b101,
        ST_TIMEOUT = 3'b110
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_RX    = 2'b00,
        MD_TX    = 2'b01,
        MD_XCVR  = 2'b10,
        MD_RSVD  = 2'b11
    } link_mode_e;

    typedef struct packed {
        seq_state_e state;
        logic       via_bus;
    } seq_regs_t;

endpackage

// File: rtl/lnk_pwrup_mode.sv
`timescale 1ns/1ps
module lnk_pwrup_mode
    import lnk_pwrup_pkg::*;
(
    input  logic [1:0] mode_i,
    output logic       is_xcvr_o
);
    link_mode_e mode;

    always_comb begin
        mode      = link_mode_e'(mode_i);
        is_xcvr_o = (mode == MD_XCVR);
    end
endmodule

// File: rtl/lnk_pwrup_sync.sv
`timescale 1ns/1ps
module lnk_pwrup_sync #(
    parameter int N_BITS = 3,
    parameter int STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N_BITS-1:0] async_i,
    output logic              all_set_o
);
    logic [N_BITS-1:0] synced;

    generate
        if (STAGES == 0) begin : g_bypass
            assign synced = async_i;
        end else begin : g_chain
            for (genvar b = 0; b < N_BITS; b++) begin : g_bit
                logic [STAGES-1:0] chain_d, chain_q;
                always_comb begin
                    if (STAGES == 1) chain_d = async_i[b];
                    else             chain_d = {chain_q[STAGES-2:0], async_i[b]};
                    if (rst_i)       chain_d = '0;
                end
                always_ff @(posedge clk_i) chain_q <= chain_d;
                assign synced[b] = chain_q[STAGES-1];
            end
        end
    endgenerate

    assign all_set_o = &synced;
endmodule

// File: rtl/lnk_pwrup_wdog.sv
`timescale 1ns/1ps
module lnk_pwrup_wdog #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [WIDTH-1:0] limit_i,
    output logic             expired_o
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run_i ? cnt_q + 1'b1 : '0;
        if (rst_i) cnt_d = '0;
    end

    always_ff @(posedge clk_i) cnt_q <= cnt_d;

    assign expired_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/lnk_pwrup_seq.sv
`timescale 1ns/1ps
module lnk_pwrup_seq
    import lnk_pwrup_pkg::*;
#(
    parameter int N_RDY       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int WDOG_W      = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fused_i,
    input  logic              fuse_done_i,
    input  logic              cfg_sel_i,
    input  logic              cfg_done_i,
    input  logic [1:0]        mode_i,
    input  logic [N_RDY-1:0]  sub_rdy_i,
    input  logic [WDOG_W-1:0] wdog_lim_i,
    output logic              fuse_req_o,
    output logic              twi_en_o,
    output logic              inband_en_o,
    output logic [2:0]        state_o,
    output logic              ready_o,
    output logic              wdog_to_o
);
    seq_regs_t r_d, r_q;
    logic      is_xcvr;
    logic      all_rdy;
    logic      wd_expired;
    logic      in_pwrup;

    lnk_pwrup_mode u_mode (
        .mode_i    (mode_i),
        .is_xcvr_o (is_xcvr)
    );

    lnk_pwrup_sync #(.N_BITS(N_RDY), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .async_i   (sub_rdy_i),
        .all_set_o (all_rdy)
    );

    assign in_pwrup = (r_q.state == ST_PWRUP);

    lnk_pwrup_wdog #(.WIDTH(WDOG_W)) u_wdog (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (in_pwrup),
        .limit_i   (wdog_lim_i),
        .expired_o (wd_expired)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_POR: begin
                if (fused_i) begin
                    r_d.state   = ST_FUSE;
                    r_d.via_bus = 1'b0;
                end else if (!cfg_sel_i) begin
                    r_d.state   = ST_BUSWAIT;
                    r_d.via_bus = 1'b1;
                end else begin
                    r_d.state   = ST_NOLINK;
                    r_d.via_bus = 1'b0;
                end
            end
            ST_FUSE:    if (fuse_done_i) r_d.state = ST_PWRUP;
            ST_BUSWAIT: if (cfg_done_i)  r_d.state = ST_PWRUP;
            ST_NOLINK:  r_d.state = ST_NOLINK;
            ST_PWRUP: begin
                if (all_rdy)         r_d.state = ST_READY;
                else if (wd_expired) r_d.state = ST_TIMEOUT;
            end
            ST_READY:   r_d.state = ST_READY;
            ST_TIMEOUT: r_d.state = ST_TIMEOUT;
            default:    r_d.state = ST_POR;
        endcase
        if (rst_i) begin
            r_d.state   = ST_POR;
            r_d.via_bus = 1'b0;
        end
    end

    always_ff @(posedge clk_i) r_q <= r_d;

    always_comb begin
        state_o     = r_q.state;
        fuse_req_o  = (r_q.state == ST_FUSE);
        ready_o     = (r_q.state == ST_READY);
        wdog_to_o   = (r_q.state == ST_TIMEOUT);
        twi_en_o    = (r_q.state == ST_READY) ||
                      (r_q.via_bus && ((r_q.state == ST_BUSWAIT) || (r_q.state == ST_PWRUP)));
        inband_en_o = is_xcvr && ((r_q.state == ST_READY) || (r_q.state == ST_NOLINK));
    end
endmodule

// File: rtl/lnk_pwrup_chk.sv
`timescale 1ns/1ps
module lnk_pwrup_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       fuse_done_i,
    input logic [2:0] state_o,
    input logic       fuse_req_o,
    input logic       twi_en_o,
    input logic       inband_en_o,
    input logic       ready_o,
    input logic       wdog_to_o
);
    a_r1_reset_state: assert property (@(posedge clk_i)
        rst_i |=> (state_o == 3'b000) && !ready_o && !fuse_req_o && !twi_en_o && !inband_en_o);

    a_r2_fuse_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 3'b001) && !fuse_done_i |=> (state_o == 3'b001));

    a_r4_nolink_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 3'b011) |=> (state_o == 3'b011));

    a_r5_ready_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ready_o) |-> ($past(state_o) == 3'b100));

    a_r6_ready_bus: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> twi_en_o);

    a_r7_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !ready_o |-> !(twi_en_o && inband_en_o));

    a_r8_timeout_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        wdog_to_o |=> wdog_to_o && !twi_en_o && !inband_en_o);

    a_r11_fuse_req: assert property (@(posedge clk_i) disable iff (rst_i)
        fuse_req_o |-> (state_o == 3'b001));
endmodule

bind lnk_pwrup_seq lnk_pwrup_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .fuse_done_i (fuse_done_i),
    .state_o     (state_o),
    .fuse_req_o  (fuse_req_o),
    .twi_en_o    (twi_en_o),
    .inband_en_o (inband_en_o),
    .ready_o     (ready_o),
    .wdog_to_o   (wdog_to_o)
);

// File: tb/lnk_pwrup_seq_test.sv
`timescale 1ns/1ps
module lnk_pwrup_seq_test;
    localparam int N_RDY  = 3;
    localparam int WDOG_W = 16;

    logic              clk = 1'b0;
    logic              rst_i = 1'b1;
    logic              fused_i = 1'b0;
    logic              fuse_done_i = 1'b0;
    logic              cfg_sel_i = 1'b0;
    logic              cfg_done_i = 1'b0;
    logic [1:0]        mode_i = 2'b00;
    logic [N_RDY-1:0]  sub_rdy_i = '0;
    logic [WDOG_W-1:0] wdog_lim_i = 16'd1000;
    logic              fuse_req_o, twi_en_o, inband_en_o, ready_o, wdog_to_o;
    logic [2:0]        state_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lnk_pwrup_seq #(.N_RDY(N_RDY), .SYNC_STAGES(2), .WDOG_W(WDOG_W)) uut (
        .clk_i(clk), .rst_i(rst_i), .fused_i(fused_i), .fuse_done_i(fuse_done_i),
        .cfg_sel_i(cfg_sel_i), .cfg_done_i(cfg_done_i), .mode_i(mode_i),
        .sub_rdy_i(sub_rdy_i), .wdog_lim_i(wdog_lim_i), .fuse_req_o(fuse_req_o),
        .twi_en_o(twi_en_o), .inband_en_o(inband_en_o), .state_o(state_o),
        .ready_o(ready_o), .wdog_to_o(wdog_to_o)
    );

    // {fused, sel, mode[1:0], mid_state[2:0], mid_twi, mid_ib, final_ib}
    localparam logic [9:0] VEC [7] = '{
        {1'b1, 1'b0, 2'b10, 3'b001, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b1, 2'b00, 3'b001, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 2'b01, 3'b010, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 2'b10, 3'b010, 1'b1, 1'b0, 1'b1},
        {1'b0, 1'b1, 2'b10, 3'b011, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b1, 2'b00, 3'b011, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 2'b11, 3'b010, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        tick(2);
        rst_i = 1'b0;
    endtask

    task automatic setup(bit f, bit s, logic [1:0] m);
        fused_i = f; cfg_sel_i = s; mode_i = m;
        cfg_done_i = 1'b0; fuse_done_i = 1'b0; sub_rdy_i = '0;
    endtask

    initial begin
        @(negedge clk);
        #1000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        check("R1 state", state_o, 0);
        check("R1 outputs", {ready_o, fuse_req_o, twi_en_o, inband_en_o, wdog_to_o}, 0);

        // table walk: R2 R3 R4 R6 R7 R9 R11
        for (int i = 0; i < 7; i++) begin
            setup(VEC[i][9], VEC[i][8], VEC[i][7:6]);
            do_reset();
            tick(2);
            check($sformatf("R2/R3/R4/R9 mid state v%0d", i), state_o, VEC[i][5:3]);
            check($sformatf("R11 fuse_req v%0d", i), fuse_req_o, VEC[i][9]);
            check($sformatf("R7 mid twi v%0d", i), twi_en_o, VEC[i][2]);
            check($sformatf("R7 mid inband v%0d", i), inband_en_o, VEC[i][1]);
            fuse_done_i = 1'b1; cfg_done_i = 1'b1; sub_rdy_i = '1;
            tick(1);
            fuse_done_i = 1'b0;
            tick(8);
            if (VEC[i][5:3] == 3'b011) begin
                check($sformatf("R4 sticky v%0d", i), state_o, 3);
                check($sformatf("R4 no twi v%0d", i), twi_en_o, 0);
                check($sformatf("R4 inband v%0d", i), inband_en_o, VEC[i][0]);
            end else begin
                check($sformatf("R5 ready v%0d", i), {state_o, ready_o}, {3'b101, 1'b1});
                check($sformatf("R6 twi v%0d", i), twi_en_o, 1);
                check($sformatf("R6 inband v%0d", i), inband_en_o, VEC[i][0]);
            end
        end

        // R6 mode toggled while ready
        mode_i = 2'b10; tick(1);
        check("R6 xcvr inband", inband_en_o, 1);
        mode_i = 2'b01; tick(1);
        check("R6 tx inband", inband_en_o, 0);

        // R10 reset out of ready
        rst_i = 1'b1; tick(1);
        check("R10 from ready", {state_o, ready_o, twi_en_o}, 0);

        // R2 fuse load held without strobe
        setup(1'b1, 1'b0, 2'b10);
        do_reset(); tick(12);
        check("R2 hold", state_o, 1);
        check("R11 req held", fuse_req_o, 1);

        // R5 partial ready keeps waiting
        fuse_done_i = 1'b1; sub_rdy_i = 3'b011; tick(1); fuse_done_i = 1'b0;
        check("R2 to pwrup", state_o, 4);
        tick(20);
        check("R5 partial", {state_o, ready_o}, {3'b100, 1'b0});
        check("R7 fused pwrup twi", twi_en_o, 0);
        sub_rdy_i = 3'b111; tick(4);
        check("R5 all ready", state_o, 5);

        // R3 bus wait
        setup(1'b0, 1'b0, 2'b10);
        do_reset(); tick(15);
        check("R3 hold", state_o, 2);
        cfg_done_i = 1'b1; tick(1);
        check("R3 pwrup", state_o, 4);
        check("R3 twi kept", twi_en_o, 1);
        check("R7 pwrup inband", inband_en_o, 0);

        // R8 watchdog exact length
        setup(1'b1, 1'b0, 2'b10);
        wdog_lim_i = 16'd5;
        do_reset(); tick(2);
        fuse_done_i = 1'b1; tick(1); fuse_done_i = 1'b0;
        begin
            int len = 0;
            while (state_o == 3'd4 && len < 100) begin
                len++;
                tick(1);
            end
            check("R8 pwrup length", len, 6);
        end
        check("R8 timeout state", state_o, 6);
        check("R8 flag", wdog_to_o, 1);
        sub_rdy_i = '1; tick(6);
        check("R8 sticky", state_o, 6);
        check("R8 paths off", {twi_en_o, inband_en_o}, 0);

        // R10 reset out of timeout
        rst_i = 1'b1; tick(1);
        check("R10 from timeout", {state_o, wdog_to_o}, 0);
        rst_i = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    end
endmodule